// File: doc/BRIEF.md
# Video Processor Host Register Port

This block sits between a host CPU bus and the rest of a tile-based video processor. It presents eight byte-wide registers selected by a 3-bit register index. The host bus connects only its three lowest address bits, so the eight registers repeat every 8 bytes across the whole decode window. Through these registers the host sets control and mask flags, reads frame status, and addresses the sprite attribute memory. It also loads scroll offsets and reaches the 14-bit video memory space through a data port.

Two of the registers, scroll and video address, take a pair of byte writes. One first/second toggle is shared between them, and a status read resets it. The data port steps the video address by 1 or by 32 after every access. Data-port reads below the palette window are delivered one access late through a read buffer. Reads inside the palette window are delivered at once. The block holds no memory. It issues read and write strobes with an address and data to the video memory and to the sprite attribute memory, and it takes their read data back in the same cycle.

Top module: `vdp_host_port`

## Requirements
- R1: `host_sel_i` picks the register: 0 control, 1 mask, 2 status, 3 object address, 4 object data, 5 scroll, 6 video address, 7 video data. A read of index 0, 1, 3, 5 or 6 returns the last byte written to any register.
- R2: A control write updates `ctrl_o` and copies data bits 1:0 into `tmp_addr_o[11:10]`. A mask write updates `mask_o`.
- R3: A status read returns {vblank flag, `sprite_hit_i`, `sprite_ovf_i`, bits 4:0 of the last written byte} in bits 7..0. It then clears the vblank flag and resets the write toggle.
- R4: The vblank flag is set by a `vblank_set_i` pulse and cleared by a `vblank_clr_i` pulse. If a status read falls in the same cycle as `vblank_set_i`, the read returns bit 7 as 0 and the flag stays clear.
- R5: The first scroll write loads `tmp_addr_o[4:0]` from data bits 7:3 and `fine_x_o` from data bits 2:0. The second scroll write loads `tmp_addr_o[14:12]` from data bits 2:0 and `tmp_addr_o[9:5]` from data bits 7:3.
- R6: The first video-address write loads `tmp_addr_o[13:8]` from data bits 5:0 and clears `tmp_addr_o[14]`. The second loads `tmp_addr_o[7:0]` and then copies `tmp_addr_o[13:0]` into `vid_addr_o`.
- R7: Scroll and video-address writes share one toggle that flips on each such write. Only reset or a status read returns it to "first".
- R8: Every video-data read or write advances `vid_addr_o` by 32 when `ctrl_o[2]` is 1 and by 1 otherwise, wrapping modulo 2^14.
- R9: A video-data read at an address below 0x3F00 returns the buffer contents and reloads the buffer from `vid_rdata_i`.
- R10: A video-data read at an address of 0x3F00 or above returns `vid_rdata_i` directly and leaves the buffer unchanged.
- R11: An object-data write raises `obj_we_o` with `obj_wdata_o` at `obj_addr_o` and then increments `obj_addr_o` modulo 256. An object-data read returns `obj_rdata_i` and leaves `obj_addr_o` unchanged.
- R12: `host_rdata_o` is registered. It takes its new value on the clock edge that ends a read and holds it until the next read.
- R13: After synchronous reset, every register, the flag, the toggle, the buffer and `host_rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_i | input | 3 | Register index (low host address bits) |
| host_rd_i | input | 1 | Host read strobe, one cycle |
| host_wr_i | input | 1 | Host write strobe, one cycle |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Registered host read data |
| vblank_set_i | input | 1 | Timing unit pulse: vertical blank begins |
| vblank_clr_i | input | 1 | Timing unit pulse: pre-render clear |
| sprite_hit_i | input | 1 | Sprite-hit flag from the timing unit |
| sprite_ovf_i | input | 1 | Sprite overflow flag from the timing unit |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| fine_x_o | output | 3 | Fine horizontal scroll |
| tmp_addr_o | output | 15 | Temporary (staging) video address |
| vid_addr_o | output | 14 | Active video address |
| vid_rd_o | output | 1 | Video memory read strobe |
| vid_we_o | output | 1 | Video memory write strobe |
| vid_wdata_o | output | 8 | Video memory write data |
| vid_rdata_i | input | 8 | Video memory data at `vid_addr_o` |
| obj_addr_o | output | 8 | Sprite attribute memory address |
| obj_we_o | output | 1 | Sprite attribute memory write strobe |
| obj_wdata_o | output | 8 | Sprite attribute memory write data |
| obj_rdata_i | input | 8 | Sprite attribute memory data at `obj_addr_o` |

## Verification
A status read and the timing unit's vblank pulse can land in the same clock, and then the read must win. The bench drives both in one cycle and expects bit 7 of the returned byte to be 0. It then expects a second status read to report 0 as well, which shows the flag was never latched. Random traffic also lets the vblank set and clear pulses fall freely on host accesses. The behavioural model settles each case by the same priority rule, and the bench compares against that model every clock.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int NREGS  = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    HR_CTRL   = 3'd0,
    HR_MASK   = 3'd1,
    HR_STAT   = 3'd2,
    HR_OADDR  = 3'd3,
    HR_ODATA  = 3'd4,
    HR_SCROLL = 3'd5,
    HR_VADDR  = 3'd6,
    HR_VDATA  = 3'd7
  } hreg_e;
endpackage

// File: rtl/vdp_host_decode.sv
module vdp_host_decode
  import vdp_port_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [NREGS-1:0] rd_hit_o,
  output logic [NREGS-1:0] wr_hit_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_dec
    assign rd_hit_o[g] = rd_i && (sel_i == SEL_W'(g));
    assign wr_hit_o[g] = wr_i && (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/vdp_scroll_regs.sv
module vdp_scroll_regs #(
  parameter int VA_W      = 14,
  parameter int STEP_WIDE = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctrl_i,
  input  logic            wr_scroll_i,
  input  logic            wr_vaddr_i,
  input  logic            data_acc_i,
  input  logic            step_wide_i,
  input  logic            toggle_clr_i,
  input  logic [7:0]      wdata_i,
  output logic [VA_W:0]   tmp_q,
  output logic [VA_W-1:0] cur_q,
  output logic [2:0]      fine_q,
  output logic            toggle_q
);
  localparam logic [VA_W-1:0] INC_WIDE   = VA_W'(STEP_WIDE);
  localparam logic [VA_W-1:0] INC_NARROW = VA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q    <= '0;
      cur_q    <= '0;
      fine_q   <= '0;
      toggle_q <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        tmp_q[11:10] <= wdata_i[1:0];
      end
      if (wr_scroll_i) begin
        if (!toggle_q) begin
          tmp_q[4:0] <= wdata_i[7:3];
          fine_q     <= wdata_i[2:0];
        end else begin
          tmp_q[14:12] <= wdata_i[2:0];
          tmp_q[9:5]   <= wdata_i[7:3];
        end
        toggle_q <= ~toggle_q;
      end
      if (wr_vaddr_i) begin
        if (!toggle_q) begin
          tmp_q[13:8] <= wdata_i[5:0];
          tmp_q[14]   <= 1'b0;
        end else begin
          tmp_q[7:0] <= wdata_i;
          cur_q      <= {tmp_q[13:8], wdata_i};
        end
        toggle_q <= ~toggle_q;
      end
      if (data_acc_i) begin
        cur_q <= cur_q + (step_wide_i ? INC_WIDE : INC_NARROW);
      end
      if (toggle_clr_i) begin
        toggle_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdp_read_path.sv
module vdp_read_path
  import vdp_port_pkg::*;
#(
  parameter int VA_W = 14,
  parameter logic [VA_W-1:0] PAL_BASE = 14'h3F00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREGS-1:0] rd_hit_i,
  input  logic             vblank_i,
  input  logic             hit_i,
  input  logic             ovf_i,
  input  logic [7:0]       last_wr_i,
  input  logic [VA_W-1:0]  cur_i,
  input  logic [7:0]       vid_rdata_i,
  input  logic [7:0]       obj_rdata_i,
  output logic [7:0]       rdata_q,
  output logic [7:0]       buf_q
);
  logic in_pal;
  logic [7:0] rnext;
  assign in_pal = (cur_i >= PAL_BASE);

  always_comb begin
    rnext = last_wr_i;
    if (rd_hit_i[HR_STAT])  rnext = {vblank_i, hit_i, ovf_i, last_wr_i[4:0]};
    if (rd_hit_i[HR_ODATA]) rnext = obj_rdata_i;
    if (rd_hit_i[HR_VDATA]) rnext = in_pal ? vid_rdata_i : buf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      buf_q   <= '0;
    end else begin
      if (|rd_hit_i) rdata_q <= rnext;
      if (rd_hit_i[HR_VDATA] && !in_pal) buf_q <= vid_rdata_i;
    end
  end
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
  import vdp_port_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int OBJ_AW    = 8,
  parameter int STEP_WIDE = 32,
  parameter logic [VA_W-1:0] PAL_BASE = 14'h3F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        host_sel_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  input  logic              vblank_set_i,
  input  logic              vblank_clr_i,
  input  logic              sprite_hit_i,
  input  logic              sprite_ovf_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [2:0]        fine_x_o,
  output logic [VA_W:0]     tmp_addr_o,
  output logic [VA_W-1:0]   vid_addr_o,
  output logic              vid_rd_o,
  output logic              vid_we_o,
  output logic [7:0]        vid_wdata_o,
  input  logic [7:0]        vid_rdata_i,
  output logic [OBJ_AW-1:0] obj_addr_o,
  output logic              obj_we_o,
  output logic [7:0]        obj_wdata_o,
  input  logic [7:0]        obj_rdata_i
);
  logic [NREGS-1:0] rd_hit, wr_hit;
  logic [7:0] last_wr_q;
  logic [7:0] rbuf_q;
  logic       vblank_q;
  logic       wr_toggle;

  vdp_host_decode u_dec (
    .sel_i    (host_sel_i),
    .rd_i     (host_rd_i),
    .wr_i     (host_wr_i),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit)
  );

  vdp_scroll_regs #(.VA_W(VA_W), .STEP_WIDE(STEP_WIDE)) u_scroll (
    .clk          (clk),
    .rst          (rst),
    .wr_ctrl_i    (wr_hit[HR_CTRL]),
    .wr_scroll_i  (wr_hit[HR_SCROLL]),
    .wr_vaddr_i   (wr_hit[HR_VADDR]),
    .data_acc_i   (wr_hit[HR_VDATA] | rd_hit[HR_VDATA]),
    .step_wide_i  (ctrl_o[2]),
    .toggle_clr_i (rd_hit[HR_STAT]),
    .wdata_i      (host_wdata_i),
    .tmp_q        (tmp_addr_o),
    .cur_q        (vid_addr_o),
    .fine_q       (fine_x_o),
    .toggle_q     (wr_toggle)
  );

  vdp_read_path #(.VA_W(VA_W), .PAL_BASE(PAL_BASE)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_hit_i    (rd_hit),
    .vblank_i    (vblank_q),
    .hit_i       (sprite_hit_i),
    .ovf_i       (sprite_ovf_i),
    .last_wr_i   (last_wr_q),
    .cur_i       (vid_addr_o),
    .vid_rdata_i (vid_rdata_i),
    .obj_rdata_i (obj_rdata_i),
    .rdata_q     (host_rdata_o),
    .buf_q       (rbuf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o     <= '0;
      mask_o     <= '0;
      obj_addr_o <= '0;
      last_wr_q  <= '0;
      vblank_q   <= 1'b0;
    end else begin
      if (host_wr_i)         last_wr_q  <= host_wdata_i;
      if (wr_hit[HR_CTRL])   ctrl_o     <= host_wdata_i;
      if (wr_hit[HR_MASK])   mask_o     <= host_wdata_i;
      if (wr_hit[HR_OADDR])  obj_addr_o <= OBJ_AW'(host_wdata_i);
      if (wr_hit[HR_ODATA])  obj_addr_o <= obj_addr_o + OBJ_AW'(1);
      if (vblank_clr_i)          vblank_q <= 1'b0;
      else if (rd_hit[HR_STAT])  vblank_q <= 1'b0;
      else if (vblank_set_i)     vblank_q <= 1'b1;
    end
  end

  assign vid_rd_o    = rd_hit[HR_VDATA];
  assign vid_we_o    = wr_hit[HR_VDATA];
  assign vid_wdata_o = host_wdata_i;
  assign obj_we_o    = wr_hit[HR_ODATA];
  assign obj_wdata_o = host_wdata_i;
endmodule

// File: rtl/vdp_host_port_chk.sv
module vdp_host_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  host_sel_i,
  input logic        host_rd_i,
  input logic        host_wr_i,
  input logic [7:0]  host_wdata_i,
  input logic [7:0]  host_rdata_o,
  input logic [7:0]  ctrl_o,
  input logic [14:0] tmp_addr_o,
  input logic [13:0] vid_addr_o,
  input logic [7:0]  obj_addr_o,
  input logic        vblank_q,
  input logic        wr_toggle
);
  // R8
  vstep_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && host_sel_i == 3'd7 && !ctrl_o[2]) |=> vid_addr_o == $past(vid_addr_o) + 14'd1);
  // R8
  vstep_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_sel_i == 3'd7 && ctrl_o[2]) |=> vid_addr_o == $past(vid_addr_o) + 14'd32);
  // R11
  oread_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_sel_i == 3'd4) |=> $stable(obj_addr_o));
  // R11
  owrite_step_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && host_sel_i == 3'd4) |=> obj_addr_o == $past(obj_addr_o) + 8'd1);
  // R3
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_sel_i == 3'd2) |=> (!vblank_q && !wr_toggle));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd_i |=> $stable(host_rdata_o));
  // R6
  vaddr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && host_sel_i == 3'd6 && wr_toggle) |=>
      vid_addr_o == {$past(tmp_addr_o[13:8]), $past(host_wdata_i)});
  // R6
  vaddr_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && host_sel_i == 3'd6 && !wr_toggle) |=> !tmp_addr_o[14]);
endmodule

bind vdp_host_port vdp_host_port_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_sel_i   (host_sel_i),
  .host_rd_i    (host_rd_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .ctrl_o       (ctrl_o),
  .tmp_addr_o   (tmp_addr_o),
  .vid_addr_o   (vid_addr_o),
  .obj_addr_o   (obj_addr_o),
  .vblank_q     (vblank_q),
  .wr_toggle    (wr_toggle)
);

// File: tb/vdp_host_port_tb.sv
`timescale 1ns/1ps
module vdp_host_port_tb;
  logic clk = 0, rst = 1;
  logic [2:0] sel = 0;
  logic rd = 0, wr = 0, vset = 0, vclr = 0, hit = 0, ovf = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata, ctrl, mask, vwd, oaddr, owd, vrd, ord;
  logic [2:0] fx;
  logic [14:0] taddr;
  logic [13:0] vaddr;
  logic vrdq, vwe, owe;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign vrd = vaddr[7:0] ^ {vaddr[13:8], 2'b00};
  assign ord = oaddr ^ 8'h5A;

  vdp_host_port u_dut (
    .clk(clk), .rst(rst), .host_sel_i(sel), .host_rd_i(rd), .host_wr_i(wr),
    .host_wdata_i(wd), .host_rdata_o(rdata), .vblank_set_i(vset), .vblank_clr_i(vclr),
    .sprite_hit_i(hit), .sprite_ovf_i(ovf), .ctrl_o(ctrl), .mask_o(mask),
    .fine_x_o(fx), .tmp_addr_o(taddr), .vid_addr_o(vaddr), .vid_rd_o(vrdq),
    .vid_we_o(vwe), .vid_wdata_o(vwd), .vid_rdata_i(vrd), .obj_addr_o(oaddr),
    .obj_we_o(owe), .obj_wdata_o(owd), .obj_rdata_i(ord)
  );

  // behavioural reference model
  int m_ctrl, m_mask, m_t, m_v, m_fx, m_tg, m_oa, m_last, m_buf, m_vb, m_rd;
  always @(posedge clk) begin
    int mem, inc;
    if (rst) begin
      m_ctrl = 0; m_mask = 0; m_t = 0; m_v = 0; m_fx = 0; m_tg = 0;
      m_oa = 0; m_last = 0; m_buf = 0; m_vb = 0; m_rd = 0;
    end else begin
      inc = (m_ctrl & 4) ? 32 : 1;
      if (wr) begin
        m_last = wd;
        case (sel)
          0: begin m_ctrl = wd; m_t = (m_t & ~32'hC00) | ((wd & 3) << 10); end
          1: m_mask = wd;
          3: m_oa = wd;
          4: m_oa = (m_oa + 1) % 256;
          5: begin
            if (m_tg == 0) begin m_t = (m_t & ~32'h1F) | (wd >> 3); m_fx = wd & 7; end
            else m_t = (m_t & ~32'h73E0) | ((wd & 7) << 12) | ((wd >> 3) << 5);
            m_tg ^= 1;
          end
          6: begin
            if (m_tg == 0) m_t = (m_t & 32'hFF) | ((wd & 32'h3F) << 8);
            else begin m_t = (m_t & 32'h7F00) | wd; m_v = m_t & 32'h3FFF; end
            m_tg ^= 1;
          end
          7: m_v = (m_v + inc) % 16384;
          default: ;
        endcase
      end else if (rd) begin
        case (sel)
          2: begin
            m_rd = (m_vb << 7) | (hit << 6) | (ovf << 5) | (m_last & 31);
            m_vb = 0; m_tg = 0;
          end
          4: m_rd = (m_oa ^ 32'h5A) & 255;
          7: begin
            mem = ((m_v & 255) ^ ((m_v >> 8) << 2)) & 255;
            if (m_v >= 32'h3F00) m_rd = mem;
            else begin m_rd = m_buf; m_buf = mem; end
            m_v = (m_v + inc) % 16384;
          end
          default: m_rd = m_last;
        endcase
      end
      if (vclr) m_vb = 0;
      else if (vset && !(rd && sel == 2)) m_vb = 1;
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 ctrl", ctrl, m_ctrl);
      chk("R2 mask", mask, m_mask);
      chk("R5 fine_x", fx, m_fx);
      chk("R5 tmp_addr", taddr, m_t);
      chk("R8 vid_addr", vaddr, m_v);
      chk("R11 obj_addr", oaddr, m_oa);
      chk("R12 rdata", rdata, m_rd);
    end
  end

  task automatic acc(bit r, bit w, int s, int d, bit vs = 0, bit vc = 0);
    @(negedge clk);
    rd = r; wr = w; sel = 3'(s); wd = 8'(d); vset = vs; vclr = vc;
    @(negedge clk);
    rd = 0; wr = 0; vset = 0; vclr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R13 reset rdata", rdata, 0);
    chk("R13 reset vaddr", vaddr, 0);
    // R1: read of a write-only index returns last written byte
    acc(0, 1, 1, 8'h3C);
    acc(1, 0, 5, 0);
    chk("R1 open read", rdata, 8'h3C);
    // R9 buffered reads
    acc(0, 1, 6, 8'h20); acc(0, 1, 6, 8'h00);
    acc(1, 0, 7, 0); chk("R9 first read from buffer", rdata, 8'h00);
    acc(1, 0, 7, 0); chk("R9 second read", rdata, 8'h80);
    // R10 palette immediate, buffer kept
    acc(0, 1, 6, 8'h3F); acc(0, 1, 6, 8'h05);
    acc(1, 0, 7, 0); chk("R10 palette immediate", rdata, 8'hF9);
    acc(0, 1, 6, 8'h21); acc(0, 1, 6, 8'h00);
    acc(1, 0, 7, 0); chk("R10 buffer unchanged", rdata, 8'h81);
    // R8 step 32 with wrap, then step 1 with wrap
    acc(0, 1, 0, 8'h04);
    acc(0, 1, 6, 8'h3F); acc(0, 1, 6, 8'hF0);
    @(negedge clk); rd = 0; wr = 1; sel = 7; wd = 8'h55; #1;
    chk("R8 write strobe", vwe, 1);
    chk("R8 write address", vaddr, 14'h3FF0);
    @(negedge clk); wr = 0;
    chk("R8 wide step wraps", vaddr, 14'h0010);
    acc(0, 1, 0, 8'h00);
    acc(0, 1, 6, 8'h3F); acc(0, 1, 6, 8'hFF);
    acc(0, 1, 7, 8'h11);
    chk("R8 narrow step wraps", vaddr, 0);
    // R2 ctrl into tmp
    acc(0, 1, 0, 8'h03);
    chk("R2 tmp nametable bits", (taddr >> 10) & 3, 3);
    // R3 status content and clearing
    hit = 1; ovf = 0;
    acc(0, 0, 0, 0, 1, 0);
    acc(0, 1, 1, 8'h1B);
    acc(1, 0, 2, 0); chk("R3 status byte", rdata, 8'hDB);
    acc(1, 0, 2, 0); chk("R3 vblank cleared by read", rdata, 8'h5B);
    hit = 0;
    // R4 race: read and set in same cycle
    acc(1, 0, 2, 0, 1, 0); chk("R4 race read bit7", rdata[7], 0);
    acc(1, 0, 2, 0); chk("R4 race flag stays clear", rdata[7], 0);
    acc(0, 0, 0, 0, 1, 0); acc(0, 0, 0, 0, 0, 1);
    acc(1, 0, 2, 0); chk("R4 clear pulse", rdata[7], 0);
    // R5 scroll pair, R6 first address write clears bit 14
    acc(0, 1, 5, 8'h7D);
    chk("R5 fine x", fx, 5);
    chk("R5 coarse x", taddr & 32'h1F, 8'h0F);
    acc(0, 1, 5, 8'h5E);
    chk("R5 fine y", (taddr >> 12) & 7, 6);
    acc(0, 1, 6, 8'hFF);
    chk("R6 bit14 cleared", taddr[14], 0);
    chk("R6 high bits", (taddr >> 8) & 32'h3F, 32'h3F);
    // R7 toggle reset by status read
    acc(1, 0, 2, 0);
    acc(0, 1, 5, 8'h00);
    acc(1, 0, 2, 0);
    acc(0, 1, 6, 8'h21); acc(0, 1, 6, 8'h08);
    chk("R7 toggle reset", vaddr, 14'h2108);
    // R11 object port
    acc(0, 1, 3, 8'h10);
    @(negedge clk); wr = 1; sel = 4; wd = 8'hAA; #1;
    chk("R11 obj write strobe", owe, 1);
    chk("R11 obj write addr", oaddr, 8'h10);
    @(negedge clk); wr = 0;
    chk("R11 obj increments", oaddr, 8'h11);
    acc(1, 0, 4, 0);
    chk("R11 obj read data", rdata, 8'h4B);
    chk("R11 obj read no step", oaddr, 8'h11);
    // R12 hold between reads
    acc(0, 1, 1, 8'h77);
    chk("R12 rdata holds", rdata, 8'h4B);
    // random traffic against model (R1 through R12)
    seed = 32'h1234;
    for (int i = 0; i < 3000; i++) begin
      int op;
      seed = seed * 1103515245 + 12345;
      op = (seed >>> 16) & 32'h7FFF;
      hit = op[9]; ovf = op[10];
      acc(op[0], !op[0], op[3:1], op[14:7], op[11] & op[12], op[13] & op[4] & op[5]);
    end
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule